// File: doc/BRIEF.md
# Priority Address-Range Router

This block sits between one bus master and a set of slave ports on a 16-bit address bus. It steers each 8-bit or 16-bit read or write to the slave that owns the address. Ownership is held in a small table of address windows. Each window has an inclusive lower bound, an inclusive upper bound and a target slave index. Windows may overlap, and when they do the entry with the lowest table index wins. The slave sees the address with its window's lower bound subtracted, so every slave decodes from zero.

Windows are loaded at run time through a map port, one entry per cycle, into the next free table slot. Once every slot is used, further map requests are discarded, and a level output reports that the table is full. An access that falls in no window is completed by a built-in default responder. A read returns all ones at the access width, and a write is dropped without any error indication.

The request and the slave select happen in the same cycle. Read data comes back one clock later with a valid strobe. A 16-bit access is decoded on its base address alone and is forwarded as a single little-endian transfer.

Top module: `arr_range_router`

## Requirements
- R1: After reset the table is empty and `map_full_o` is 0. Each accepted map request fills the next free slot, starting at index 0. `map_full_o` is 1 once all `N_RGN` slots are filled. A map request while the table is full changes nothing.
- R2: An address matches a window when lower <= address <= upper. Both bounds are included, and the addresses one below the lower bound and one above the upper bound do not match.
- R3: When several valid windows match, the access goes to the slave of the window with the lowest table index.
- R4: `s_addr_o` equals `m_addr_i` minus the lower bound of the winning window.
- R5: In the cycle of a matched request, `s_req_o` has exactly one bit set: bit k, where k is the winning window's slave index. `s_we_o`, `s_wide_o` and `s_wdata_o` follow the master inputs. `s_req_o` is all zero when there is no request or no match.
- R6: For a read, `m_rvalid_o` is 1 in the cycle after the request and 0 otherwise. The data is the selected slave's `s_rdata_i` word for a 16-bit read (`m_wide_i`=1). For an 8-bit read it is that word's low byte with the upper byte 0.
- R7: An unmatched read returns 16'h00FF for an 8-bit access and 16'hFFFF for a 16-bit access, with `m_rvalid_o` set one cycle later.
- R8: A write produces no `m_rvalid_o`. An unmatched write asserts no `s_req_o` bit.
- R9: A 16-bit access is decoded on its base address only. A 16-bit access at a window's upper bound goes to that window's slave as one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| map_valid_i | input | 1 | Map request strobe |
| map_lo_i | input | 16 | Window lower bound, inclusive |
| map_hi_i | input | 16 | Window upper bound, inclusive |
| map_slv_i | input | SLV_W | Target slave index |
| map_full_o | output | 1 | Table full; map requests are ignored |
| m_req_i | input | 1 | Master access strobe |
| m_we_i | input | 1 | 1 = write, 0 = read |
| m_wide_i | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| m_addr_i | input | 16 | Master address |
| m_wdata_i | input | 16 | Write data, little-endian |
| m_rvalid_o | output | 1 | Read data valid |
| m_rdata_o | output | 16 | Read data |
| s_req_o | output | N_SLV | One-hot slave select |
| s_we_o | output | 1 | Write enable to slaves |
| s_wide_o | output | 1 | Width to slaves |
| s_addr_o | output | 16 | Window-relative address |
| s_wdata_o | output | 16 | Write data to slaves |
| s_rdata_i | input | N_SLV*16 | Slave read data, one word per slave, valid one cycle after select |

## Verification
The bench builds the router with its defaults, four slaves and eight table slots. Four slaves are enough to tell every routing decision apart by the slave identity each model stamps into its read data. Eight slots are few enough that the bench can fill the table, observe `map_full_o` rise, and then show that a ninth window is discarded. The loaded windows include an overlapping pair and a fully shadowed window. Each window edge is probed from both sides.

// File: rtl/arr_pkg.sv
package arr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/arr_rgn_table.sv
module arr_rgn_table
  import arr_pkg::*;
#(
  parameter int N_RGN = 8,
  parameter int SLV_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        map_valid_i,
  input  addr_t                       map_lo_i,
  input  addr_t                       map_hi_i,
  input  logic [SLV_W-1:0]            map_slv_i,
  output logic [N_RGN-1:0]            vld_o,
  output logic [N_RGN-1:0][ADDR_W-1:0] lo_o,
  output logic [N_RGN-1:0][ADDR_W-1:0] hi_o,
  output logic [N_RGN-1:0][SLV_W-1:0] slv_o,
  output logic                        full_o
);
  localparam int CNT_W = $clog2(N_RGN + 1);

  logic [CNT_W-1:0] cnt_q;

  assign full_o = (cnt_q == CNT_W'(N_RGN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (map_valid_i && !full_o) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N_RGN; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[i] <= 1'b0;
        lo_o[i]  <= '0;
        hi_o[i]  <= '0;
        slv_o[i] <= '0;
      end else if (map_valid_i && !full_o && cnt_q == CNT_W'(i)) begin
        vld_o[i] <= 1'b1;
        lo_o[i]  <= map_lo_i;
        hi_o[i]  <= map_hi_i;
        slv_o[i] <= map_slv_i;
      end
    end
  end
endmodule

// File: rtl/arr_match.sv
module arr_match
  import arr_pkg::*;
#(
  parameter int N_RGN = 8,
  localparam int IDX_W = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic [N_RGN-1:0]             vld_i,
  input  logic [N_RGN-1:0][ADDR_W-1:0] lo_i,
  input  logic [N_RGN-1:0][ADDR_W-1:0] hi_i,
  input  addr_t                        addr_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [N_RGN-1:0] hit_vec;

  for (genvar i = 0; i < N_RGN; i++) begin : g_cmp
    assign hit_vec[i] = vld_i[i] && (addr_i >= lo_i[i]) && (addr_i <= hi_i[i]);
  end

  assign hit_o = |hit_vec;

  // walk downward so the lowest matching index is left in idx_o
  always_comb begin
    idx_o = '0;
    for (int i = N_RGN - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/arr_range_router.sv
module arr_range_router
  import arr_pkg::*;
#(
  parameter int N_SLV = 4,
  parameter int N_RGN = 8,
  localparam int SLV_W = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        map_valid_i,
  input  logic [15:0]                 map_lo_i,
  input  logic [15:0]                 map_hi_i,
  input  logic [SLV_W-1:0]            map_slv_i,
  output logic                        map_full_o,
  input  logic                        m_req_i,
  input  logic                        m_we_i,
  input  logic                        m_wide_i,
  input  logic [15:0]                 m_addr_i,
  input  logic [15:0]                 m_wdata_i,
  output logic                        m_rvalid_o,
  output logic [15:0]                 m_rdata_o,
  output logic [N_SLV-1:0]            s_req_o,
  output logic                        s_we_o,
  output logic                        s_wide_o,
  output logic [15:0]                 s_addr_o,
  output logic [15:0]                 s_wdata_o,
  input  logic [N_SLV*16-1:0]         s_rdata_i
);
  localparam int IDX_W = (N_RGN > 1) ? $clog2(N_RGN) : 1;

  logic [N_RGN-1:0]             rgn_vld;
  logic [N_RGN-1:0][ADDR_W-1:0] rgn_lo;
  logic [N_RGN-1:0][ADDR_W-1:0] rgn_hi;
  logic [N_RGN-1:0][SLV_W-1:0]  rgn_slv;
  logic                         hit;
  logic [IDX_W-1:0]             idx;
  logic [SLV_W-1:0]             sel_slv;
  logic [N_SLV-1:0][DATA_W-1:0] rd_words;

  logic             rvalid_q, rd_hit_q, rd_wide_q;
  logic [SLV_W-1:0] rd_slv_q;
  data_t            rd_word;

  arr_rgn_table #(.N_RGN(N_RGN), .SLV_W(SLV_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .map_valid_i(map_valid_i),
    .map_lo_i   (map_lo_i),
    .map_hi_i   (map_hi_i),
    .map_slv_i  (map_slv_i),
    .vld_o      (rgn_vld),
    .lo_o       (rgn_lo),
    .hi_o       (rgn_hi),
    .slv_o      (rgn_slv),
    .full_o     (map_full_o)
  );

  arr_match #(.N_RGN(N_RGN)) u_match (
    .vld_i (rgn_vld),
    .lo_i  (rgn_lo),
    .hi_i  (rgn_hi),
    .addr_i(m_addr_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  assign sel_slv   = rgn_slv[idx];
  assign s_req_o   = (m_req_i && hit) ? (N_SLV'(1) << sel_slv) : '0;
  assign s_addr_o  = m_addr_i - rgn_lo[idx];
  assign s_we_o    = m_we_i;
  assign s_wide_o  = m_wide_i;
  assign s_wdata_o = m_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      rd_hit_q  <= 1'b0;
      rd_wide_q <= 1'b0;
      rd_slv_q  <= '0;
    end else begin
      rvalid_q <= m_req_i && !m_we_i;
      if (m_req_i && !m_we_i) begin
        rd_hit_q  <= hit;
        rd_wide_q <= m_wide_i;
        rd_slv_q  <= sel_slv;
      end
    end
  end

  assign rd_words = s_rdata_i;
  assign rd_word  = rd_words[rd_slv_q];

  // unmatched reads complete against the all-ones default responder
  always_comb begin
    if (rd_hit_q) m_rdata_o = rd_wide_q ? rd_word : {8'h00, rd_word[7:0]};
    else          m_rdata_o = rd_wide_q ? 16'hFFFF : 16'h00FF;
  end

  assign m_rvalid_o = rvalid_q;
endmodule

// File: rtl/arr_router_chk.sv
module arr_router_chk #(
  parameter int N_SLV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             map_full_o,
  input logic             m_req_i,
  input logic             m_we_i,
  input logic [15:0]      m_addr_i,
  input logic             m_rvalid_o,
  input logic [N_SLV-1:0] s_req_o,
  input logic [15:0]      s_addr_o
);
  a_r1_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_full_o |=> map_full_o);

  a_r4_addr_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_req_o != '0) |-> (s_addr_o <= m_addr_i));

  a_r5_req_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_req_o));

  a_r5_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_req_i |-> (s_req_o == '0));

  a_r6_rvalid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && !m_we_i) |=> m_rvalid_o);

  a_r8_write_no_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && m_we_i) |=> !m_rvalid_o);
endmodule

bind arr_range_router arr_router_chk #(.N_SLV(N_SLV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .map_full_o(map_full_o),
  .m_req_i   (m_req_i),
  .m_we_i    (m_we_i),
  .m_addr_i  (m_addr_i),
  .m_rvalid_o(m_rvalid_o),
  .s_req_o   (s_req_o),
  .s_addr_o  (s_addr_o)
);

// File: tb/arr_range_router_tb.sv
module arr_range_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_SLV = 4;
  localparam int N_RGN = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        map_valid_i = 1'b0;
  logic [15:0] map_lo_i = '0, map_hi_i = '0;
  logic [1:0]  map_slv_i = '0;
  logic        map_full_o;
  logic        m_req_i = 1'b0, m_we_i = 1'b0, m_wide_i = 1'b0;
  logic [15:0] m_addr_i = '0, m_wdata_i = '0;
  logic        m_rvalid_o;
  logic [15:0] m_rdata_o;
  logic [N_SLV-1:0] s_req_o;
  logic        s_we_o, s_wide_o;
  logic [15:0] s_addr_o, s_wdata_o;
  logic [N_SLV*16-1:0] s_rdata_i;
  logic [N_SLV-1:0][15:0] slv_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  arr_range_router #(.N_SLV(N_SLV), .N_RGN(N_RGN)) u_dut (.*);

  // slave models: registered word = {slave id, low 12 bits of relative address}
  always @(posedge clk_i) begin
    for (int j = 0; j < N_SLV; j++)
      if (s_req_o[j]) slv_q[j] <= {4'(j), s_addr_o[11:0]};
  end
  assign s_rdata_i = slv_q;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic map_rgn(input logic [15:0] lo, input logic [15:0] hi, input logic [1:0] slv);
    @(negedge clk_i);
    map_valid_i = 1'b1; map_lo_i = lo; map_hi_i = hi; map_slv_i = slv;
    @(negedge clk_i);
    map_valid_i = 1'b0;
  endtask

  // one access; exp_slv < 0 means no window should match
  task automatic access(input string req, input bit we, input bit wide, input logic [15:0] addr,
                        input logic [15:0] wdata, input int exp_slv,
                        input logic [15:0] exp_saddr, input logic [15:0] exp_rdata);
    logic [N_SLV-1:0] exp_req;
    exp_req = (exp_slv < 0) ? '0 : N_SLV'(1) << exp_slv;
    @(negedge clk_i);
    m_req_i = 1'b1; m_we_i = we; m_wide_i = wide; m_addr_i = addr; m_wdata_i = wdata;
    #1;
    chk(s_req_o == exp_req, {req, " select"}, 32'(s_req_o), 32'(exp_req));
    if (exp_slv >= 0) begin
      chk(s_addr_o == exp_saddr, {req, " offset"}, 32'(s_addr_o), 32'(exp_saddr));
      chk(s_we_o == we && s_wide_o == wide && s_wdata_o == wdata, {req, " passthru"},
          {s_we_o, s_wide_o, 14'h0, s_wdata_o}, {we, wide, 14'h0, wdata});
    end
    @(negedge clk_i);
    m_req_i = 1'b0;
    #1;
    chk(m_rvalid_o == !we, {req, " rvalid"}, 32'(m_rvalid_o), 32'(!we));
    if (!we) chk(m_rdata_o == exp_rdata, {req, " rdata"}, 32'(m_rdata_o), 32'(exp_rdata));
  endtask

  task automatic t_reset();
    #1;
    chk(s_req_o == '0, "R5 reset select", 32'(s_req_o), 0);
    chk(m_rvalid_o == 1'b0, "R6 reset rvalid", 32'(m_rvalid_o), 0);
    chk(map_full_o == 1'b0, "R1 reset full", 32'(map_full_o), 0);
  endtask

  task automatic t_setup();
    map_rgn(16'h1000, 16'h1FFF, 2'd1); // idx0
    map_rgn(16'h0000, 16'h7FFF, 2'd0); // idx1 overlaps idx0
    map_rgn(16'hC000, 16'hC0FF, 2'd2); // idx2
    map_rgn(16'hC080, 16'hC0FF, 2'd3); // idx3 shadowed by idx2
    map_rgn(16'hC100, 16'hC1FF, 2'd3); // idx4
    chk(map_full_o == 1'b0, "R1 partial table", 32'(map_full_o), 0);
  endtask

  task automatic t_edges();
    access("R2 below lower edge", 0, 1, 16'h0FFF, 0, 0, 16'h0FFF, 16'h0FFF);
    access("R2 lower edge",       0, 1, 16'h1000, 0, 1, 16'h0000, 16'h1000);
    access("R9 wide at upper",    0, 1, 16'h1FFF, 0, 1, 16'h0FFF, 16'h1FFF);
    access("R2 above upper edge", 0, 1, 16'h2000, 0, 0, 16'h2000, 16'h0000);
  endtask

  task automatic t_overlap();
    access("R3 shadowed window", 0, 1, 16'hC080, 0, 2, 16'h0080, 16'h2080);
    access("R3 earlier wins",    0, 1, 16'h1234, 0, 1, 16'h0234, 16'h1234);
  endtask

  task automatic t_offset_byte();
    access("R4 R6 byte read", 0, 0, 16'hC105, 0, 3, 16'h0005, 16'h0005);
    access("R4 base zero",    0, 1, 16'h0123, 0, 0, 16'h0123, 16'h0123);
  endtask

  task automatic t_unmapped();
    access("R7 byte default", 0, 0, 16'h8000, 0, -1, 0, 16'h00FF);
    access("R7 wide default", 0, 1, 16'hC200, 0, -1, 0, 16'hFFFF);
    access("R8 unmapped write", 1, 1, 16'h9000, 16'h1234, -1, 0, 0);
  endtask

  task automatic t_write();
    access("R5 R8 mapped write", 1, 1, 16'hC110, 16'hBEEF, 3, 16'h0010, 0);
    @(negedge clk_i); #1;
    chk(s_req_o == '0, "R5 idle no select", 32'(s_req_o), 0);
  endtask

  task automatic t_fill();
    map_rgn(16'hE000, 16'hE00F, 2'd1);
    map_rgn(16'hE010, 16'hE01F, 2'd2);
    chk(map_full_o == 1'b0, "R1 seven slots", 32'(map_full_o), 0);
    map_rgn(16'hE020, 16'hE02F, 2'd3);
    chk(map_full_o == 1'b1, "R1 table full", 32'(map_full_o), 1);
    map_rgn(16'hF000, 16'hF0FF, 2'd1);
    chk(map_full_o == 1'b1, "R1 stays full", 32'(map_full_o), 1);
    access("R1 late slot used",   0, 1, 16'hE02F, 0, 3, 16'h000F, 16'h300F);
    access("R1 overflow ignored", 0, 1, 16'hF000, 0, -1, 0, 16'hFFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_setup();
    t_edges();
    t_overlap();
    t_offset_byte();
    t_unmapped();
    t_write();
    t_fill();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule